// File: doc/BRIEF.md
# Prioritized Vectoring Interrupt Controller

This block gathers thirteen interrupt request lines, numbered 1 to 13, and presents one request at a time to the processor. It presents the request as a 3-bit interrupt level and an 8-bit exception vector. Each source has an 8-bit control byte. Bits 4:2 of that byte give the interrupt level and bits 1:0 give a priority inside that level. Bit 7 of the byte selects autovectoring. A 16-bit mask register blocks sources, and a read-only pending register mirrors the request lines.

On every cycle the block compares the combined 5-bit level-and-priority fields of all unmasked pending sources. It registers the level and vector of the winner. When autovectoring is off, the vector comes from one of three programmable vector bytes: one for the watchdog source and one for each of two serial ports. Any other source gets a fixed default vector.

Software programs the registers over a simple synchronous write port. It reads them back through a combinational read port.

Top module: `prio_vector_intc`

## Requirements
- R1: The active set is the pending bits ANDed with the inverted mask. Bit i of the mask register (byte offset 0x36) belongs to source i. A mask bit of 1 blocks that source, and mask bits 0, 14 and 15 have no effect.
- R2: The winner is the active source whose control bits 4:0 hold the largest value. When two sources tie, the lower-numbered source wins.
- R3: If there is no active source, or if the winning 5-bit value is below 4, then both the level output and the vector output are 0.
- R4: The level output equals bits 4:2 of the winner's control byte.
- R5: When bit 7 of the winner's control byte is 1, the vector is 24 plus the level.
- R6: When bit 7 of the winner's control byte is 0, the vector depends on the source. Source 8 uses the watchdog vector byte at offset 0x42. Source 12 uses the serial-0 vector byte at 0x44, and source 13 uses the serial-1 vector byte at 0x45. Every other source gives 0x0F.
- R7: After reset, the mask register reads 0x3FFE and all three vector bytes read 0x0F. The control bytes of sources 1 to 13 read 04, 08, 0C, 10, 14, 18, 1C, 1C, 80, 80, 80, 00, 00.
- R8: The pending register at offset 0x3A has bit i set when request line i was high at the previous clock edge. Request input bit k carries source k+1.
- R9: The pending register is read-only. A write to 0x3A changes neither its contents nor the outputs.
- R10: The level and vector outputs change on the clock edge after a register write takes effect. A change on a request line reaches the outputs two edges after it is sampled.
- R11: The control byte of source i reads at offset 0x13+i in the low byte. Offsets that map to no register read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqIn | input | 13 | Request lines; bit k is source k+1 |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Write byte offset |
| wrData | input | 16 | Write data; byte registers use bits 7:0 |
| rdAddr | input | 8 | Read byte offset |
| rdData | output | 16 | Read data (combinational) |
| irqLevel | output | 3 | Presented interrupt level, 0 = none |
| irqVector | output | 8 | Presented exception vector |

## Verification
The vector table runs one fixed set of control bytes against several request and mask patterns. These patterns separate the following cases:
- a single source, which shows the level is taken from bits 4:2;
- two sources at different values, which shows the comparison uses the full 5-bit field;
- an exact tie, which shows the tie goes to the lower number;
- a masked higher source, which shows the mask is applied before arbitration;
- a sub-threshold source, which shows suppression;
- sources that differ only in bit 7 or in source number, which show each vector path.

Directed tests cover the reset contents, the pending readback, the ignored write to the pending register, and the exact cycle at which the outputs move.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NUM_SRC    = 13;
  localparam int ADDR_W     = 8;
  localparam int DATA_W     = 16;
  localparam int CTRL_W     = 8;
  localparam int SRC_W      = $clog2(NUM_SRC + 1);
  localparam int CTRL_BASE  = 'h14;
  localparam int MASK_ADDR  = 'h36;
  localparam int PEND_ADDR  = 'h3A;
  localparam int WDVEC_ADDR = 'h42;
  localparam int SER0_ADDR  = 'h44;
  localparam int SER1_ADDR  = 'h45;
  localparam int WD_SRC     = 8;
  localparam int SER0_SRC   = 12;
  localparam int SER1_SRC   = 13;
  localparam int AUTO_BASE  = 24;
  localparam int MIN_VALUE  = 4;
  localparam logic [7:0] DEFAULT_VEC = 8'h0F;
  localparam logic [DATA_W-1:0] MASK_RESET = 16'h3FFE;

  typedef struct packed {
    logic [NUM_SRC:1] ctrlWe;
    logic             maskWe;
    logic             wdVecWe;
    logic [1:0]       serVecWe;
  } vic_strobe_t;

  function automatic logic [CTRL_W-1:0] ctrlResetVal(input int src);
    case (src)
      1: return 8'h04;
      2: return 8'h08;
      3: return 8'h0C;
      4: return 8'h10;
      5: return 8'h14;
      6: return 8'h18;
      7, 8: return 8'h1C;
      9, 10, 11: return 8'h80;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output vic_strobe_t       stb
);
  always_comb begin
    stb = '0;
    for (int i = 1; i <= NUM_SRC; i++)
      stb.ctrlWe[i] = wrEn && (wrAddr == ADDR_W'(CTRL_BASE + i - 1));
    stb.maskWe      = wrEn && (wrAddr == ADDR_W'(MASK_ADDR));
    stb.wdVecWe     = wrEn && (wrAddr == ADDR_W'(WDVEC_ADDR));
    stb.serVecWe[0] = wrEn && (wrAddr == ADDR_W'(SER0_ADDR));
    stb.serVecWe[1] = wrEn && (wrAddr == ADDR_W'(SER1_ADDR));
  end
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  vic_strobe_t        stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [2:0]         irqLevel,
  output logic [7:0]         irqVector
);
  logic [CTRL_W-1:0] ctrlReg [1:NUM_SRC];
  logic [DATA_W-1:0] maskReg;
  logic [NUM_SRC:1]  pendReg;
  logic [7:0]        wdVec;
  logic [7:0]        serVec [2];
  logic [NUM_SRC:1]  activeSet;
  logic [4:0]        bestVal;
  logic [SRC_W-1:0]  bestSrc;
  logic [CTRL_W-1:0] bestCtrl;
  logic              winValid;
  logic [2:0]        nextLevel;
  logic [7:0]        nextVector;

  for (genvar g = 1; g <= NUM_SRC; g++) begin : gCtrl
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)               ctrlReg[g] <= ctrlResetVal(g);
      else if (stb.ctrlWe[g])  ctrlReg[g] <= wrData[CTRL_W-1:0];
  end

  for (genvar s = 0; s < 2; s++) begin : gSerVec
    always_ff @(posedge clk or negedge rstN)
      if (!rstN)               serVec[s] <= DEFAULT_VEC;
      else if (stb.serVecWe[s]) serVec[s] <= wrData[7:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg   <= MASK_RESET;
      wdVec     <= DEFAULT_VEC;
      pendReg   <= '0;
      irqLevel  <= '0;
      irqVector <= '0;
    end else begin
      if (stb.maskWe)  maskReg <= wrData;
      if (stb.wdVecWe) wdVec   <= wrData[7:0];
      pendReg   <= reqIn;
      irqLevel  <= nextLevel;
      irqVector <= nextVector;
    end
  end

  assign activeSet = pendReg & ~maskReg[NUM_SRC:1];

  // Strictly-greater scan in ascending source order: ties keep the lower number.
  always_comb begin
    bestVal  = '0;
    bestSrc  = '0;
    bestCtrl = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (activeSet[i] && (ctrlReg[i][4:0] > bestVal)) begin
        bestVal  = ctrlReg[i][4:0];
        bestSrc  = SRC_W'(i);
        bestCtrl = ctrlReg[i];
      end
    end
    winValid  = (bestVal >= 5'(MIN_VALUE));
    nextLevel = winValid ? bestCtrl[4:2] : 3'd0;
    if (!winValid)        nextVector = 8'd0;
    else if (bestCtrl[7]) nextVector = 8'(AUTO_BASE) + {5'd0, bestCtrl[4:2]};
    else begin
      case (bestSrc)
        SRC_W'(WD_SRC):   nextVector = wdVec;
        SRC_W'(SER0_SRC): nextVector = serVec[0];
        SRC_W'(SER1_SRC): nextVector = serVec[1];
        default:          nextVector = DEFAULT_VEC;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 1; i <= NUM_SRC; i++)
      if (rdAddr == ADDR_W'(CTRL_BASE + i - 1)) rdData[CTRL_W-1:0] = ctrlReg[i];
    case (rdAddr)
      ADDR_W'(MASK_ADDR):  rdData = maskReg;
      ADDR_W'(PEND_ADDR):  rdData[NUM_SRC:1] = pendReg;
      ADDR_W'(WDVEC_ADDR): rdData[7:0] = wdVec;
      ADDR_W'(SER0_ADDR):  rdData[7:0] = serVec[0];
      ADDR_W'(SER1_ADDR):  rdData[7:0] = serVec[1];
      default: ;
    endcase
  end

  // R3: nothing active means silent outputs next cycle
  p_idle_silent_r3: assert property (@(posedge clk) disable iff (!rstN)
    (activeSet == '0) |=> (irqLevel == 3'd0 && irqVector == 8'd0));
  // R3: a zero level never carries a vector
  p_zero_level_no_vec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == 3'd0) |-> (irqVector == 8'd0));
  // R5: autovector winner yields base plus presented level
  p_autovector_r5: assert property (@(posedge clk) disable iff (!rstN)
    (winValid && bestCtrl[7]) |=> (irqVector == 8'(AUTO_BASE) + {5'd0, irqLevel}));
  // R8: pending mirrors the request lines one edge later
  p_pend_follows_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (pendReg == $past(reqIn)));
  // R1: the mask changes only on its own write strobe
  p_mask_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !stb.maskWe |=> $stable(maskReg));
  // R11: decoded write strobes never overlap
  p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.ctrlWe, stb.maskWe, stb.wdVecWe, stb.serVecWe}));
endmodule

// File: rtl/prio_vector_intc.sv
module prio_vector_intc
  import vic_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic [2:0]         irqLevel,
  output logic [7:0]         irqVector
);
  vic_strobe_t stb;

  vic_ctrl uCtrl (
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .stb    (stb)
  );

  vic_datapath uData (
    .clk       (clk),
    .rstN      (rstN),
    .reqIn     (reqIn),
    .stb       (stb),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .irqLevel  (irqLevel),
    .irqVector (irqVector)
  );
endmodule

// File: tb/prio_vector_intc_test.sv
module prio_vector_intc_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [12:0] reqIn = '0;
  logic        wrEn = 1'b0;
  logic [7:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [7:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic [2:0]  irqLevel;
  logic [7:0]  irqVector;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  prio_vector_intc uut (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .irqLevel(irqLevel), .irqVector(irqVector)
  );

  // {mask, request (bit i = source i), level, vector}
  localparam logic [47:0] VECS [16] = '{
    {16'h0000, 16'h0000, 8'd0, 8'h00},
    {16'h0000, 16'h0002, 8'd1, 8'h0F},
    {16'h0000, 16'h000A, 8'd3, 8'h0F},
    {16'h0000, 16'h0180, 8'd7, 8'h0F},
    {16'h0000, 16'h0100, 8'd7, 8'h40},
    {16'h0080, 16'h0180, 8'd7, 8'h40},
    {16'h0000, 16'h0200, 8'd3, 8'h1B},
    {16'h0000, 16'h0400, 8'd0, 8'h00},
    {16'h0000, 16'h0600, 8'd3, 8'h1B},
    {16'h0000, 16'h3000, 8'd5, 8'h50},
    {16'h0000, 16'h2000, 8'd5, 8'h60},
    {16'h0000, 16'h1800, 8'd5, 8'h1D},
    {16'h0000, 16'h3FFE, 8'd7, 8'h0F},
    {16'hFFFF, 16'h3FFE, 8'd0, 8'h00},
    {16'hEFFF, 16'h3FFE, 8'd5, 8'h50},
    {16'h0001, 16'h0002, 8'd1, 8'h0F}
  };

  localparam logic [7:0] RESET_CTRL [13] = '{
    8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
    8'h1C, 8'h80, 8'h80, 8'h80, 8'h00, 8'h00
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic writeReg(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [15:0] d);
    rdAddr = a;
    #1;
    d = rdData;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R7: reset contents
    check("R7 level after reset", 16'(irqLevel), 16'h0);
    check("R7 vector after reset", 16'(irqVector), 16'h0);
    readReg(8'h36, rd); check("R7 mask reset", rd, 16'h3FFE);
    readReg(8'h42, rd); check("R7 watchdog vector reset", rd, 16'h000F);
    readReg(8'h44, rd); check("R7 serial0 vector reset", rd, 16'h000F);
    readReg(8'h45, rd); check("R7 serial1 vector reset", rd, 16'h000F);
    for (int i = 1; i <= 13; i++) begin
      readReg(8'(8'h13 + i), rd);
      check("R7 R11 control reset", rd, {8'h00, RESET_CTRL[i-1]});
    end
    // R11: unmapped offset reads zero
    readReg(8'h37, rd); check("R11 unmapped read", rd, 16'h0000);

    // Shared configuration for the table
    writeReg(8'h1C, 16'h008D); // source 9: value 13, level 3, auto
    writeReg(8'h1D, 16'h0003); // source 10: value 3, below threshold
    writeReg(8'h1E, 16'h0097); // source 11: value 23, level 5, auto
    writeReg(8'h1F, 16'h0016); // source 12: value 22, level 5
    writeReg(8'h20, 16'h0016); // source 13: value 22, level 5
    writeReg(8'h42, 16'h0040);
    writeReg(8'h44, 16'h0050);
    writeReg(8'h45, 16'h0060);
    readReg(8'h1F, rd); check("R11 control write readback", rd, 16'h0016);

    // R1 R2 R3 R4 R5 R6: table walk
    for (int row = 0; row < 16; row++) begin
      writeReg(8'h36, VECS[row][47:32]);
      reqIn = VECS[row][29:17];
      settle();
      check($sformatf("R1 R2 R3 R4 row %0d level", row), 16'(irqLevel), 16'(VECS[row][15:8]));
      check($sformatf("R5 R6 row %0d vector", row), 16'(irqVector), 16'(VECS[row][7:0]));
    end

    // R8: pending readback, with everything masked
    writeReg(8'h36, 16'hFFFF);
    reqIn = 13'h1555;
    settle();
    readReg(8'h3A, rd); check("R8 pending readback", rd, {2'b00, 13'h1555, 1'b0});

    // R9: write to pending ignored (contents and outputs)
    writeReg(8'h3A, 16'h0000);
    readReg(8'h3A, rd); check("R9 pending unchanged by write", rd, {2'b00, 13'h1555, 1'b0});
    @(negedge clk);
    check("R9 level unchanged by pending write", 16'(irqLevel), 16'h0);

    // R10: exact timing of a mask write
    reqIn = 13'h0004;            // source 3: level 3
    settle();
    writeReg(8'h36, 16'h0000);   // write lands at the edge just passed
    check("R10 level one edge after write (old)", 16'(irqLevel), 16'h0);
    @(negedge clk);
    check("R10 level two edges after write (new)", 16'(irqLevel), 16'h3);

    // R10: request path takes two edges
    @(negedge clk);
    reqIn = 13'h0044;            // adds source 7: level 7
    @(negedge clk);
    check("R10 R8 pending after one edge", 16'(irqLevel), 16'h3);
    @(negedge clk);
    check("R10 level after two edges", 16'(irqLevel), 16'h7);

    // R4: control rewrite moves the presented level
    writeReg(8'h1A, 16'h0008);   // source 7 down to level 2
    @(negedge clk);
    check("R4 level follows control rewrite", 16'(irqLevel), 16'h3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule